// File: doc/BRIEF.md
# Multi-Channel Threshold Watchdog Monitor

This block watches conversion results from up to eight channels of a filtered converter. Each result arrives as a signed word with a channel index and an end-of-conversion strobe. The block first corrects the result with that channel's own offset and right shift. It then compares the corrected value against one high limit and one low limit, which all channels share. A crossing sets a sticky per-channel flag, which stays set until software writes a one to its clear bit. A global flag shows whether any flag is set. Four break lines give a fast hardware reaction. For each line, a high-crossing mask and a low-crossing mask choose whether that kind of event drives it.

The block is built around a small two-state sequencer. In `ST_IDLE` no result is pending. An accepted strobe (transition `T_ACCEPT`) captures the corrected value and the channel index and moves the sequencer to `ST_JUDGE`. In `ST_JUDGE` the captured value is compared, and the flags and break lines are updated on the next edge. If another accepted strobe arrives during `ST_JUDGE`, the sequencer stays there (`T_CHAIN`), so results can arrive on every cycle. With no accepted strobe, the sequencer returns to idle (`T_DONE`). A strobe on a disabled channel is not accepted, and the sequencer stays in idle (`T_STAY`).

Top module: `thresh_watchdog_mon`

## Requirements
- R1: The corrected value is the result minus the channel's signed 24-bit offset. This difference saturates to the range -8388608..8388607, and is then shifted right arithmetically by the channel's 5-bit shift amount (0..31). Channel k's offset sits at `ofs_bus[24k+23:24k]` and its shift amount at `shift_bus[5k+4:5k]`.
- R2: A result is evaluated only when `res_eoc` is 1 and bit `res_chan` of `chan_mask` is 1. A strobe for a channel whose mask bit is 0 changes no flag and drives no break line.
- R3: The comparisons are signed and strict. A corrected value greater than `thr_high` sets bit `res_chan` of `hi_flags`. A value less than `thr_low` sets bit `res_chan` of `lo_flags`. A value equal to either limit sets nothing.
- R4: Each flag is sticky. Only a 1 on its own bit of `clr_high` or `clr_low` clears it. If a set and a clear reach the same flag in the same cycle, the set wins.
- R5: `wd_any` is 1 exactly when at least one of the sixteen flags is 1. It drops only after every flag has been cleared.
- R6: Break line i goes high for exactly one cycle when the evaluated result either crosses high with `brk_hi_sel[i]`=1 or crosses low with `brk_lo_sel[i]`=1.
- R7: A result strobed in the cycle before clock edge A shows up in the flags and the break lines after the following edge B, two edges after the strobe is sampled.
- R8: A synchronous active-high `rst` clears all flags, `wd_any` and all break lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_data | input | 24 | Signed conversion result |
| res_chan | input | 3 | Channel index of the result |
| res_eoc | input | 1 | End-of-conversion strobe |
| chan_mask | input | 8 | Channel enable mask for comparison |
| thr_high | input | 24 | Signed high limit |
| thr_low | input | 24 | Signed low limit |
| ofs_bus | input | 192 | Per-channel signed offsets, 24 bits each |
| shift_bus | input | 40 | Per-channel right-shift amounts, 5 bits each |
| clr_high | input | 8 | Write-one-to-clear strobes for high flags |
| clr_low | input | 8 | Write-one-to-clear strobes for low flags |
| brk_hi_sel | input | 4 | Break lines driven by a high crossing |
| brk_lo_sel | input | 4 | Break lines driven by a low crossing |
| hi_flags | output | 8 | Sticky high-crossing flags per channel |
| lo_flags | output | 8 | Sticky low-crossing flags per channel |
| wd_any | output | 1 | Global watchdog flag |
| brk | output | 4 | Registered break pulses |

## Verification
The assertions check four properties on every cycle:
- A flag never drops without its clear bit.
- A set always lands, even when a clear arrives with it.
- The global flag never falls without a clear write.
- A break pulse always traces back to a judged crossing, and a masked strobe never leads to one.

Other behaviour can only be shown by the bench's scenarios: the arithmetic values of offset correction, saturation and shifting; strictness at the exact limits; which flag bit and which break lines a given result reaches; and the two-edge latency.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_JUDGE = 1'b1
    } wdm_state_t;
endpackage

// File: rtl/wdm_correct.sv
module wdm_correct #(
    parameter int DW = 24,
    parameter int SW = 5
) (
    input  logic signed [DW-1:0] raw,
    input  logic signed [DW-1:0] ofs,
    input  logic        [SW-1:0] shamt,
    output logic signed [DW-1:0] corr
);
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW:0]   diff;
    logic signed [DW-1:0] sat;

    always_comb begin
        diff = {raw[DW-1], raw} - {ofs[DW-1], ofs};
        if (diff[DW] != diff[DW-1])
            sat = diff[DW] ? MINV : MAXV;
        else
            sat = diff[DW-1:0];
        corr = sat >>> shamt;
    end
endmodule

// File: rtl/wdm_flag_bank.sv
module wdm_flag_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_vec,
    input  logic [NCH-1:0] clr_vec,
    output logic [NCH-1:0] flags
);
    for (genvar g = 0; g < NCH; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[g] <= 1'b0;
            else if (set_vec[g])
                flags[g] <= 1'b1;
            else if (clr_vec[g])
                flags[g] <= 1'b0;
        end
    end

    // R4: a requested set always lands, clear or not
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R4: no flag drops unless its own clear bit was written
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags != '0) |=> ((~flags & $past(flags) & ~$past(clr_vec)) == '0));
endmodule

// File: rtl/wdm_break_route.sv
module wdm_break_route #(
    parameter int NBRK = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hi_evt,
    input  logic            lo_evt,
    input  logic [NBRK-1:0] hi_sel,
    input  logic [NBRK-1:0] lo_sel,
    output logic [NBRK-1:0] brk
);
    for (genvar b = 0; b < NBRK; b++) begin : g_brk
        always_ff @(posedge clk) begin
            if (rst)
                brk[b] <= 1'b0;
            else
                brk[b] <= (hi_evt & hi_sel[b]) | (lo_evt & lo_sel[b]);
        end
    end

    // R6: a pulse on a break line always follows a judged crossing
    a_r6_brk_from_event: assert property (@(posedge clk) disable iff (rst)
        (hi_evt == 1'b0 && lo_evt == 1'b0) |=> (brk == '0));
endmodule

// File: rtl/thresh_watchdog_mon.sv
module thresh_watchdog_mon
    import wdm_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int DW   = 24,
    parameter int SW   = 5,
    parameter int NBRK = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DW-1:0]     res_data,
    input  logic [$clog2(NCH)-1:0]   res_chan,
    input  logic                     res_eoc,
    input  logic [NCH-1:0]           chan_mask,
    input  logic signed [DW-1:0]     thr_high,
    input  logic signed [DW-1:0]     thr_low,
    input  logic [NCH*DW-1:0]        ofs_bus,
    input  logic [NCH*SW-1:0]        shift_bus,
    input  logic [NCH-1:0]           clr_high,
    input  logic [NCH-1:0]           clr_low,
    input  logic [NBRK-1:0]          brk_hi_sel,
    input  logic [NBRK-1:0]          brk_lo_sel,
    output logic [NCH-1:0]           hi_flags,
    output logic [NCH-1:0]           lo_flags,
    output logic                     wd_any,
    output logic [NBRK-1:0]          brk
);
    localparam int CW = $clog2(NCH);

    wdm_state_t          state, state_nx;
    logic                accept;
    logic signed [DW-1:0] corr_now;
    logic signed [DW-1:0] stg_val;
    logic [CW-1:0]       stg_ch;
    logic                hi_evt, lo_evt;
    logic [NCH-1:0]      set_hi, set_lo;

    assign accept = res_eoc & chan_mask[res_chan];

    wdm_correct #(.DW(DW), .SW(SW)) u_corr (
        .raw   (res_data),
        .ofs   (ofs_bus[res_chan*DW +: DW]),
        .shamt (shift_bus[res_chan*SW +: SW]),
        .corr  (corr_now)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // capture of an accepted result
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_val <= '0;
            stg_ch  <= '0;
        end else if (accept) begin
            stg_val <= corr_now;
            stg_ch  <= res_chan;
        end
    end

    // next state and judge outputs
    always_comb begin
        state_nx = ST_IDLE;
        hi_evt   = 1'b0;
        lo_evt   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                state_nx = accept ? ST_JUDGE : ST_IDLE;
            end
            ST_JUDGE: begin
                state_nx = accept ? ST_JUDGE : ST_IDLE;
                hi_evt   = (stg_val > thr_high);
                lo_evt   = (stg_val < thr_low);
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        assign set_hi[c] = hi_evt && (stg_ch == CW'(c));
        assign set_lo[c] = lo_evt && (stg_ch == CW'(c));
    end

    wdm_flag_bank #(.NCH(NCH)) u_hi_bank (
        .clk(clk), .rst(rst), .set_vec(set_hi), .clr_vec(clr_high), .flags(hi_flags)
    );

    wdm_flag_bank #(.NCH(NCH)) u_lo_bank (
        .clk(clk), .rst(rst), .set_vec(set_lo), .clr_vec(clr_low), .flags(lo_flags)
    );

    assign wd_any = (hi_flags != '0) || (lo_flags != '0);

    wdm_break_route #(.NBRK(NBRK)) u_brk (
        .clk(clk), .rst(rst), .hi_evt(hi_evt), .lo_evt(lo_evt),
        .hi_sel(brk_hi_sel), .lo_sel(brk_lo_sel), .brk(brk)
    );

    // R2: a strobe on a disabled channel never reaches a break line
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (res_eoc && !chan_mask[res_chan] && state == ST_IDLE) |=> ##1 (brk == '0));

    // R5: the global flag only falls after a clear write
    a_r5_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
        (wd_any == 1'b1) |=> (wd_any || ($past(clr_high) != '0) || ($past(clr_low) != '0)));

    // R7: the judge state is entered only after an accepted strobe
    a_r7_judge_after_accept: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (state == ST_IDLE));
endmodule

// File: tb/thresh_watchdog_mon_tb.sv
module thresh_watchdog_mon_tb;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [23:0] res_data = '0;
    logic [2:0]         res_chan = '0;
    logic               res_eoc = 1'b0;
    logic [7:0]         chan_mask = 8'b1011_1111;
    logic signed [23:0] thr_high = 24'sd1000;
    logic signed [23:0] thr_low = -24'sd1000;
    logic [191:0]       ofs_bus = '0;
    logic [39:0]        shift_bus = '0;
    logic [7:0]         clr_high = '0;
    logic [7:0]         clr_low = '0;
    logic [3:0]         brk_hi_sel = 4'b0101;
    logic [3:0]         brk_lo_sel = 4'b0010;
    logic [7:0]         hi_flags, lo_flags;
    logic               wd_any;
    logic [3:0]         brk;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    thresh_watchdog_mon u_dut (
        .clk(clk), .rst(rst), .res_data(res_data), .res_chan(res_chan),
        .res_eoc(res_eoc), .chan_mask(chan_mask), .thr_high(thr_high),
        .thr_low(thr_low), .ofs_bus(ofs_bus), .shift_bus(shift_bus),
        .clr_high(clr_high), .clr_low(clr_low), .brk_hi_sel(brk_hi_sel),
        .brk_lo_sel(brk_lo_sel), .hi_flags(hi_flags), .lo_flags(lo_flags),
        .wd_any(wd_any), .brk(brk)
    );

    // {chan, data, expect high, expect low}
    localparam logic [28:0] VEC [13] = '{
        {3'd0,  24'sd1001,     1'b1, 1'b0},
        {3'd0,  24'sd1000,     1'b0, 1'b0},
        {3'd0, -24'sd1000,     1'b0, 1'b0},
        {3'd0, -24'sd1001,     1'b0, 1'b1},
        {3'd1,  24'sd1501,     1'b1, 1'b0},
        {3'd1,  24'sd1500,     1'b0, 1'b0},
        {3'd2,  24'sd4004,     1'b1, 1'b0},
        {3'd2,  24'sd4003,     1'b0, 1'b0},
        {3'd2, -24'sd4008,     1'b0, 1'b1},
        {3'd3,  24'sd8388600,  1'b1, 1'b0},
        {3'd4, -24'sd8388600,  1'b0, 1'b1},
        {3'd6,  24'sd5000,     1'b0, 1'b0},
        {3'd7, -24'sd5000000,  1'b0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // drive one strobe at a falling edge, return at the falling edge where results show
    task automatic strobe(input logic [2:0] ch, input logic signed [23:0] d);
        res_chan = ch;
        res_data = d;
        res_eoc  = 1'b1;
        @(negedge clk);
        res_eoc  = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_high = 8'hFF;
        clr_low  = 8'hFF;
        @(negedge clk);
        clr_high = '0;
        clr_low  = '0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] eb;
        ofs_bus[1*24 +: 24]   = 24'sd500;
        ofs_bus[3*24 +: 24]   = -24'sd100;
        ofs_bus[4*24 +: 24]   = 24'sd100;
        shift_bus[2*5 +: 5]   = 5'd2;
        shift_bus[3*5 +: 5]   = 5'd13;
        shift_bus[4*5 +: 5]   = 5'd13;
        shift_bus[7*5 +: 5]   = 5'd31;

        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 hi_flags", hi_flags, 0);
        check("R8 lo_flags", lo_flags, 0);
        check("R8 wd_any", wd_any, 0);
        check("R8 brk", brk, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R6 R7: table of results
        for (int i = 0; i < 13; i++) begin
            logic [2:0] ch;
            logic eh, el;
            ch = VEC[i][28:26];
            eh = VEC[i][1];
            el = VEC[i][0];
            clear_all();
            strobe(ch, VEC[i][25:2]);
            eb = 8'(1) << ch;
            check("R3 hi_flags", hi_flags, eh ? eb : 0);
            check("R3 lo_flags", lo_flags, el ? eb : 0);
            check("R5 wd_any", wd_any, (eh | el) ? 1 : 0);
            check("R6 brk pulse", brk, (eh ? 4'b0101 : 4'b0000) | (el ? 4'b0010 : 4'b0000));
            @(negedge clk);
            check("R6 brk one cycle", brk, 0);
        end

        // R4: sticky through a quiet result, wrong clear bit has no effect
        clear_all();
        strobe(3'd0, 24'sd2000);
        strobe(3'd0, 24'sd0);
        check("R4 sticky", hi_flags, 8'h01);
        clr_low = 8'h01;
        @(negedge clk);
        clr_low = '0;
        check("R4 other clear ignored", hi_flags, 8'h01);
        clr_high = 8'h01;
        @(negedge clk);
        clr_high = '0;
        check("R4 clear", hi_flags, 0);

        // R4: set wins over a clear in the same cycle
        res_chan = 3'd5; res_data = -24'sd3000; res_eoc = 1'b1;
        @(negedge clk);
        res_eoc = 1'b0; clr_low = 8'h20;
        @(negedge clk);
        clr_low = '0;
        check("R4 set wins", lo_flags, 8'h20);

        // R5: global flag holds until last flag cleared
        strobe(3'd0, 24'sd1200);
        clr_low = 8'h20;
        @(negedge clk);
        clr_low = '0;
        check("R5 still set", wd_any, 1);
        clr_high = 8'h01;
        @(negedge clk);
        clr_high = '0;
        check("R5 dropped", wd_any, 0);

        // R2: masked channel leaves flags and breaks untouched
        res_chan = 3'd6; res_data = 24'sd9000; res_eoc = 1'b1;
        @(negedge clk);
        res_eoc = 1'b0;
        check("R2 no brk early", brk, 0);
        @(negedge clk);
        check("R2 masked flags", {hi_flags, lo_flags}, 0);
        check("R2 masked brk", brk, 0);

        // R7: back-to-back strobes on two channels
        res_chan = 3'd0; res_data = 24'sd5000; res_eoc = 1'b1;
        @(negedge clk);
        res_chan = 3'd5; res_data = -24'sd5000;
        check("R7 not yet", hi_flags, 0);
        @(negedge clk);
        res_eoc = 1'b0;
        check("R7 first lands", hi_flags, 8'h01);
        check("R7 first brk", brk, 4'b0101);
        @(negedge clk);
        check("R7 second lands", lo_flags, 8'h20);
        check("R7 second brk", brk, 4'b0010);

        // R8: reset clears flags
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset clears", {hi_flags, lo_flags, 4'b0, brk}, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule